// File: doc/BRIEF.md
# I2C Bus Busy Monitor

This block keeps one status bit saying whether a two-wire serial bus is occupied. It samples the raw data line (SDA) and clock line (SCL) through a synchroniser and a level filter. Any low level on either filtered line marks the bus as occupied. A stop condition, which is a rise of the data line while the clock line is high, marks the bus as free again and is also sent out as a one-cycle pulse. Disabling the interface or reporting a bus error also frees the bus.

The controller around this block uses the flag to decide whether it may start a transfer. It uses the stop pulse to end its own transfer state. The synchroniser depth and the filter length are parameters. Together they set how long a line level must hold before the block acts on it.

Top module: `i2c_busy_mon`

## Requirements
- R1: With the enable at 1 and no clear pending, a filtered low level on SDA or on SCL sets `busy_o` to 1 on the next clock. A `busy_o` of 0 means idle and 1 means a transfer is in progress.
- R2: A stop condition clears `busy_o` and produces a `stop_o` pulse exactly one cycle wide. A stop condition is the filtered SDA going from 0 to 1 while the filtered SCL is 1.
- R3: While `en_i` is 0, `busy_o` is 0 from the next clock on and ignores the line levels, and `stop_o` stays 0.
- R4: A 1 on `ber_i` clears `busy_o` on the next clock.
- R5: When a clear (disable, bus error or stop) and a set occur in the same cycle, the clear wins for that cycle.
- R6: Each line passes through `SYNC_STAGES` (at least 2) flops before being judged. A low level held on an idle bus raises `busy_o` exactly `SYNC_STAGES + FILT_LEN + 1` clocks after it is applied.
- R7: A synchronised level change is accepted only after it has held for `FILT_LEN` consecutive clocks. Shorter pulses have no effect on `busy_o` or `stop_o`.
- R8: SDA rising while SCL is 0 is data, not a stop. It produces no `stop_o` pulse and leaves `busy_o` at 1.
- R9: After reset, `busy_o` and `stop_o` are 0 and both filtered lines read as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Interface enable; 0 forces the flag idle |
| ber_i | input | 1 | Bus error report; 1 clears the flag |
| sda_i | input | 1 | Raw data line sample, asynchronous |
| scl_i | input | 1 | Raw clock line sample, asynchronous |
| busy_o | output | 1 | Bus occupied flag (1 = transfer in progress) |
| stop_o | output | 1 | One-cycle stop condition pulse |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `FILT_LEN` = 3. With a filter longer than one clock, the counter variant of the filter is the one that runs. That makes a rejected two-clock glitch and an accepted three-clock pulse both reachable. The six-clock latency from a line falling to the flag rising can then be checked to the exact cycle. The bench also makes a bus error coincide with a low line, so that the clear-over-set priority is visible at the flag.

// File: rtl/i2cbm_pkg.sv
package i2cbm_pkg;
   typedef struct packed {
      logic sda;
      logic scl;
   } line_pair_t;

   localparam int unsigned NUM_LINES = 2;
   localparam logic        LINE_IDLE = 1'b1;
endpackage

// File: rtl/i2cbm_sync.sv
module i2cbm_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cbm_filt.sv
module i2cbm_filt #(
   parameter int unsigned LEN     = 3,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

   generate
      if (LEN == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RST_VAL;
            else        q <= d;
         end
      end else begin : g_count
         logic [CW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q   <= RST_VAL;
               run <= '0;
            end else if (d == q) begin
               run <= '0;
            end else if (run == CW'(LEN - 1)) begin
               q   <= d;
               run <= '0;
            end else begin
               run <= run + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2cbm_stopdet.sv
module i2cbm_stopdet (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sda_f,
   input  logic scl_f,
   output logic stop_now,
   output logic stop_q
);
   logic sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_prev <= 1'b1;
      else        sda_prev <= sda_f;
   end

   assign stop_now = en & scl_f & sda_f & ~sda_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= stop_now;
   end
endmodule

// File: rtl/i2cbm_busyflag.sv
module i2cbm_busyflag (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ber,
   input  logic stop_now,
   input  logic sda_f,
   input  logic scl_f,
   output logic busy
);
   logic clr, set;

   assign clr = ~en | ber | stop_now;
   assign set = ~sda_f | ~scl_f;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   busy <= 1'b0;
      else if (clr) busy <= 1'b0;
      else if (set) busy <= 1'b1;
   end
endmodule

// File: rtl/i2c_busy_mon.sv
module i2c_busy_mon
   import i2cbm_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic ber_i,
   input  logic sda_i,
   input  logic scl_i,
   output logic busy_o,
   output logic stop_o
);
   initial begin
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
      assert (FILT_LEN >= 1)    else $error("FILT_LEN must be at least 1");
   end

   line_pair_t raw, syn, flt;
   logic       stop_now;
   logic       sda_flt, scl_flt;

   assign raw.sda = sda_i;
   assign raw.scl = scl_i;

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         i2cbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(LINE_IDLE)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw[i]), .q(syn[i]));
         i2cbm_filt #(.LEN(FILT_LEN), .RST_VAL(LINE_IDLE)) u_filt (
            .clk(clk), .rst_n(rst_n), .d(syn[i]), .q(flt[i]));
      end
   endgenerate

   assign sda_flt = flt.sda;
   assign scl_flt = flt.scl;

   i2cbm_stopdet u_stop (
      .clk(clk), .rst_n(rst_n), .en(en_i), .sda_f(sda_flt), .scl_f(scl_flt),
      .stop_now(stop_now), .stop_q(stop_o));

   i2cbm_busyflag u_busy (
      .clk(clk), .rst_n(rst_n), .en(en_i), .ber(ber_i), .stop_now(stop_now),
      .sda_f(sda_flt), .scl_f(scl_flt), .busy(busy_o));
endmodule

// File: rtl/i2c_busy_mon_chk.sv
module i2c_busy_mon_chk (
   input logic clk,
   input logic rst_n,
   input logic en_i,
   input logic ber_i,
   input logic sda_f,
   input logic scl_f,
   input logic busy_o,
   input logic stop_o
);
   AST_SET_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !ber_i && (!sda_f || !scl_f)) |=> busy_o); // R1
   AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o); // R2
   AST_STOP_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> !busy_o); // R2
   AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!busy_o && !stop_o)); // R3
   AST_BER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ber_i |=> !busy_o); // R4
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ber_i && !scl_f) |=> !busy_o); // R5
   AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> ($past(scl_f) && $past(sda_f))); // R8
endmodule

bind i2c_busy_mon i2c_busy_mon_chk u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .ber_i(ber_i),
   .sda_f(sda_flt), .scl_f(scl_flt), .busy_o(busy_o), .stop_o(stop_o));

// File: tb/i2c_busy_mon_test.sv
module i2c_busy_mon_test;
   localparam int S = 2;
   localparam int F = 3;
   localparam int LAT = S + F + 1;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, ber = 1'b0, sda = 1'b1, scl = 1'b1;
   logic busy, stop;
   int total = 0, bad = 0, stops = 0;
   bit run = 0, done = 0;

   always #4 clk = ~clk;

   i2c_busy_mon #(.SYNC_STAGES(S), .FILT_LEN(F)) uut (
      .clk(clk), .rst_n(rst_n), .en_i(en), .ber_i(ber), .sda_i(sda), .scl_i(scl),
      .busy_o(busy), .stop_o(stop));

   // behavioural reference
   bit qs[$], qc[$];
   bit fs, fc, ps, mb, mst;
   int cs, cc;

   always @(posedge clk) begin
      if (!rst_n) begin
         qs = {}; qc = {};
         for (int i = 0; i < S; i++) begin qs.push_back(1); qc.push_back(1); end
         fs = 1; fc = 1; ps = 1; mb = 0; mst = 0; cs = 0; cc = 0;
      end else begin
         bit sn, sy_s, sy_c;
         sn  = en && fc && fs && !ps;
         mst = sn;
         if (!en || ber || sn) mb = 0;
         else if (!fs || !fc) mb = 1;
         ps = fs;
         sy_s = qs[S-1]; sy_c = qc[S-1];
         if (sy_s == fs) cs = 0;
         else if (cs == F-1) begin fs = sy_s; cs = 0; end
         else cs++;
         if (sy_c == fc) cc = 0;
         else if (cc == F-1) begin fc = sy_c; cc = 0; end
         else cc++;
         void'(qs.pop_back()); qs.push_front(sda);
         void'(qc.pop_back()); qc.push_front(scl);
      end
   end

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) if (run) begin
      chk("busy model R1 R2 R3 R4 R5 R6", busy, mb);
      chk("stop model R2 R8", stop, mst);
      if (stop) stops++;
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      cyc(3);
      chk("R9 reset busy", busy, 1'b0);
      chk("R9 reset stop", stop, 1'b0);
      rst_n = 1'b1; cyc(1); run = 1; en = 1'b1; cyc(10);
      chk("R1 idle stays 0", busy, 1'b0);
      // R6 latency
      sda = 1'b0;
      cyc(LAT - 1); chk("R6 not yet busy", busy, 1'b0);
      cyc(1);       chk("R6 busy at latency", busy, 1'b1);
      // R8 data toggles
      stops = 0;
      for (int k = 0; k < 3; k++) begin
         scl = 1'b0; cyc(8); sda = ~sda; cyc(8); scl = 1'b1; cyc(8);
      end
      scl = 1'b0; cyc(8); sda = 1'b1; cyc(10);
      chk("R8 no stop on data rise", stops == 0, 1'b1);
      chk("R8 still busy", busy, 1'b1);
      // R2 stop
      sda = 1'b0; cyc(8); scl = 1'b1; cyc(8); stops = 0; sda = 1'b1; cyc(12);
      chk("R2 single stop pulse", stops == 1, 1'b1);
      chk("R2 idle after stop", busy, 1'b0);
      // R1 via scl alone
      scl = 1'b0; cyc(10);
      chk("R1 scl low sets busy", busy, 1'b1);
      // R4 / R5 clear wins with line low
      ber = 1'b1; cyc(1);
      chk("R5 clear wins over set", busy, 1'b0);
      chk("R4 ber clears", busy, 1'b0);
      ber = 1'b0; cyc(1);
      chk("R1 set again after ber", busy, 1'b1);
      // R3 disable
      en = 1'b0; cyc(1);
      chk("R3 disable clears", busy, 1'b0);
      stops = 0;
      scl = 1'b1; cyc(8); sda = 1'b0; cyc(8); sda = 1'b1; cyc(8); scl = 1'b0; cyc(8);
      chk("R3 lines ignored", busy, 1'b0);
      chk("R3 no stop while off", stops == 0, 1'b1);
      scl = 1'b1; cyc(10); en = 1'b1; cyc(10);
      chk("R3 idle when re-enabled", busy, 1'b0);
      // R7 glitch rejection then acceptance
      sda = 1'b0; cyc(F - 1); sda = 1'b1; cyc(12);
      chk("R7 short glitch ignored", busy, 1'b0);
      sda = 1'b0; cyc(F); sda = 1'b1; cyc(12);
      chk("R7 full length accepted", busy, 1'b0);
      chk("R7 accepted pulse made stop", stops == 1, 1'b1);
      run = 0; done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule